// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Register

This block merges six reset requests into one system reset and keeps a record of the cause that software can read. The six requests are power-on, brown-out, external pin, watchdog timeout, software command and configuration mismatch. Brown-out, pin and watchdog requests arrive asynchronously and pass through a two-flop synchronizer first. Software and configuration-mismatch requests are already on the system clock and act at once. After power-on the block can add a power-up delay. It then holds the system reset until the configuration has been reloaded and the clock is stable. The core reset is released a fixed number of cycles after the system reset falls.

The cause register is a set of sticky flags. Hardware sets them by a per-cause rule, and software can read and rewrite them. There are four write addresses: plain write, clear-by-ones, set-by-ones and toggle-by-ones. If a watchdog timeout arrives while the core is in a low-power state, the block raises a wake indication and does not reset.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Any active request forces `sys_rst` high. `sw_req` and `cfg_mismatch` are sampled on a clock edge and `sys_rst` is high after that same edge. `bor_req`, `pin_req` and `wdt_req` (outside low power) pass a two-flop synchronizer, so `sys_rst` is high after the third edge that samples them high.
- R2: Once a request is gone, `sys_rst` stays high until `cfg_loaded` and `clk_stable` are both sampled high. It falls after that edge.
- R3: `core_rst` is high whenever `sys_rst` is high, and it falls exactly `CORE_DLY` (default 8) cycles after `sys_rst` falls.
- R4: After `por_n` is released there are two cycles of internal reset release. With `regulator_en` low, a power-up wait of `PU_CYCLES` cycles follows, then one cycle of configuration wait. With `regulator_en` high, the power-up wait is skipped.
- R5: A read at offset 0x0 returns the flags in these bit positions: 9 configuration mismatch, 8 regulator-standby enable, 7 pin, 6 software, 4 watchdog, 3 woke-from-sleep, 2 woke-from-idle, 1 brown-out, 0 power-on. Bit 5 and bits 31:10 read 0. Reads at 0x4, 0x8 and 0xC return 0.
- R6: While `por_n` is low, both resets are high and the flags hold 0x003 (power-on and brown-out set).
- R7: A brown-out sets bit 1 and clears every other bit except bit 0 and bit 8.
- R8: A pin, software, watchdog or mismatch reset sets only its own flag. A pin reset also sets bit 3 when `in_sleep` is high and bit 2 when `in_idle` is high.
- R9: A synchronized watchdog request while `in_sleep` or `in_idle` is high does not raise `sys_rst` and leaves the flags unchanged. It drives `wake_evt` high after the third edge that samples `wdt_req` high.
- R10: A write at 0x0 loads the flags, at 0x4 clears the bits written as 1, at 0x8 sets them, and at 0xC toggles them. Bit 5 and bits above 9 always stay 0.
- R11: Bus writes to the flags never change `sys_rst` or `core_rst`.
- R12: When a hardware cause and a bus write land on the same edge, the bus write is applied first and the hardware flag update is applied on top of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| regulator_en | input | 1 | On-chip regulator enabled; when high the power-up wait is skipped |
| cfg_loaded | input | 1 | Configuration reload finished |
| clk_stable | input | 1 | Clock source stable |
| bor_req | input | 1 | Brown-out request, asynchronous, active high |
| pin_req | input | 1 | External pin reset request, asynchronous, active high |
| wdt_req | input | 1 | Watchdog timeout, asynchronous, active high |
| sw_req | input | 1 | Software reset command, synchronous strobe |
| cfg_mismatch | input | 1 | Configuration mismatch, synchronous |
| in_sleep | input | 1 | Core is in sleep |
| in_idle | input | 1 | Core is in idle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the access kind |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sys_rst | output | 1 | System reset, active high |
| core_rst | output | 1 | Core reset, active high |
| wake_evt | output | 1 | Watchdog wake indication during low power |

## Verification
Each result is due a fixed number of edges after its stimulus. Synchronous requests show on `sys_rst` one edge later. Asynchronous requests and the low-power wake show three edges later. Release follows one edge after readiness, the core reset falls `CORE_DLY` edges after the system reset, and a read returns data in the same cycle. The bench drives inputs on falling edges and updates a behavioural model on rising edges from those same inputs. It compares every output shortly after each falling edge. Directed checks count falling edges from a stimulus until the output changes and compare that count with the latencies above.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int FLAG_W = 10;

  localparam int B_POR   = 0;
  localparam int B_BOR   = 1;
  localparam int B_IDLE  = 2;
  localparam int B_SLEEP = 3;
  localparam int B_WDT   = 4;
  localparam int B_SW    = 6;
  localparam int B_PIN   = 7;
  localparam int B_STBY  = 8;
  localparam int B_CFG   = 9;

  localparam logic [FLAG_W-1:0] IMPL_MASK = 10'h3DF;
  localparam logic [FLAG_W-1:0] POR_VALUE = 10'h003;

  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_LOAD  = 2'd1,
    ST_RUN   = 2'd2
  } rst_state_e;

  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_CLR    = 2'd1,
    OP_SET    = 2'd2,
    OP_INV    = 2'd3
  } wr_op_e;

  typedef struct packed {
    logic cfg;
    logic sw;
    logic wdt;
    logic pin;
    logic bor;
  } cause_t;
endpackage

// File: rtl/rstc_req_sync.sv
module rstc_req_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_async[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q_sync[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int PU_CYCLES = 6400000,
  parameter int CORE_DLY  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic reg_en,
  input  logic cfg_loaded,
  input  logic clk_stable,
  input  logic wake_req,
  output logic sys_rst,
  output logic core_rst,
  output logic wake_evt
);
  localparam int PU_W   = $clog2(PU_CYCLES + 1);
  localparam int CORE_W = $clog2(CORE_DLY + 1);
  localparam logic [PU_W-1:0]   PU_LAST   = PU_W'(PU_CYCLES - 1);
  localparam logic [CORE_W-1:0] CORE_LAST = CORE_W'(CORE_DLY);

  rst_state_e        state_q, state_d;
  logic [PU_W-1:0]   pu_q, pu_d;
  logic              pu_en;
  logic [CORE_W-1:0] core_q, core_d;
  logic              wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWRUP: if (reg_en || pu_q == PU_LAST) state_d = ST_LOAD;
      ST_LOAD:  if (cfg_loaded && clk_stable)  state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      default:  state_d = ST_LOAD;
    endcase
    if (any_req) state_d = ST_LOAD;
  end

  assign pu_en = (state_q == ST_PWRUP) && !reg_en;
  assign pu_d  = pu_q + 1'b1;

  always_comb begin
    if (state_q != ST_RUN)      core_d = '0;
    else if (core_q != CORE_LAST) core_d = core_q + 1'b1;
    else                        core_d = core_q;
  end

  assign wake_d = wake_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      pu_q    <= '0;
      core_q  <= '0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pu_en) pu_q <= pu_d;
      core_q  <= core_d;
      wake_q  <= wake_d;
    end
  end

  assign sys_rst  = (state_q != ST_RUN);
  assign core_rst = sys_rst || (core_q != CORE_LAST);
  assign wake_evt = wake_q;
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cause_t            cause,
  input  logic              in_sleep,
  input  logic              in_idle,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [FLAG_W-1:0] KEEP_ON_BOR =
    (FLAG_W'(1) << B_POR) | (FLAG_W'(1) << B_STBY);

  logic [FLAG_W-1:0] flags_q, flags_d, bus_next, wmask;
  logic              wr_en, hw_en, flags_en;
  wr_op_e            op;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[DATA_W-1:FLAG_W], bus_addr[1:0]};
  assign op    = wr_op_e'(bus_addr[3:2]);
  assign wmask = bus_wdata[FLAG_W-1:0] & IMPL_MASK;
  assign wr_en = bus_sel && bus_wr;
  assign hw_en = cause.bor | cause.pin | cause.wdt | cause.sw | cause.cfg;
  assign flags_en = wr_en || hw_en;

  always_comb begin
    bus_next = flags_q;
    if (wr_en) begin
      unique case (op)
        OP_DIRECT: bus_next = wmask;
        OP_CLR:    bus_next = flags_q & ~wmask;
        OP_SET:    bus_next = flags_q | wmask;
        OP_INV:    bus_next = flags_q ^ wmask;
        default:   bus_next = flags_q;
      endcase
    end
  end

  always_comb begin
    flags_d = bus_next;
    if (cause.bor) begin
      flags_d        = bus_next & KEEP_ON_BOR;
      flags_d[B_BOR] = 1'b1;
    end else begin
      if (cause.pin)             flags_d[B_PIN]   = 1'b1;
      if (cause.pin && in_sleep) flags_d[B_SLEEP] = 1'b1;
      if (cause.pin && in_idle)  flags_d[B_IDLE]  = 1'b1;
      if (cause.sw)              flags_d[B_SW]    = 1'b1;
      if (cause.wdt)             flags_d[B_WDT]   = 1'b1;
      if (cause.cfg)             flags_d[B_CFG]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= POR_VALUE;
    else if (flags_en) flags_q <= flags_d;
  end

  assign bus_rdata = (bus_sel && !bus_wr && op == OP_DIRECT) ? DATA_W'(flags_q) : '0;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int PU_CYCLES   = 6400000,
  parameter int CORE_DLY    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              regulator_en,
  input  logic              cfg_loaded,
  input  logic              clk_stable,
  input  logic              bor_req,
  input  logic              pin_req,
  input  logic              wdt_req,
  input  logic              sw_req,
  input  logic              cfg_mismatch,
  input  logic              in_sleep,
  input  logic              in_idle,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst,
  output logic              core_rst,
  output logic              wake_evt
);
  localparam int N_ASYNC = 3;

  logic               rst_n_int;
  logic [N_ASYNC-1:0] async_raw, async_sync;
  logic               low_power;
  cause_t             cause;
  logic               any_req;

  rstc_req_sync #(.N(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .d_async (1'b1),
    .q_sync  (rst_n_int)
  );

  assign async_raw = {wdt_req, pin_req, bor_req};

  rstc_req_sync #(.N(N_ASYNC), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (async_raw),
    .q_sync  (async_sync)
  );

  assign low_power = in_sleep || in_idle;

  always_comb begin
    cause.bor = async_sync[0];
    cause.pin = async_sync[1];
    cause.wdt = async_sync[2] && !low_power;
    cause.sw  = sw_req;
    cause.cfg = cfg_mismatch;
  end

  assign any_req = cause.bor | cause.pin | cause.wdt | cause.sw | cause.cfg;

  rstc_seq #(.PU_CYCLES(PU_CYCLES), .CORE_DLY(CORE_DLY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .any_req    (any_req),
    .reg_en     (regulator_en),
    .cfg_loaded (cfg_loaded),
    .clk_stable (clk_stable),
    .wake_req   (async_sync[2] && low_power),
    .sys_rst    (sys_rst),
    .core_rst   (core_rst),
    .wake_evt   (wake_evt)
  );

  rstc_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cause     (cause),
    .in_sleep  (in_sleep),
    .in_idle   (in_idle),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
  parameter int CORE_DLY = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic              clk,
  input logic              por_n,
  input logic              cfg_loaded,
  input logic              clk_stable,
  input logic              sw_req,
  input logic              cfg_mismatch,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sys_rst,
  input logic              core_rst
);
  localparam int GAP_W = $clog2(CORE_DLY + 2);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(CORE_DLY);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            gap_q <= '0;
    else if (sys_rst)      gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  AST_SYNC_SRC_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (sw_req || cfg_mismatch) |=> sys_rst); // R1

  AST_RELEASE_NEEDS_READY: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> $past(cfg_loaded && clk_stable)); // R2

  AST_CORE_COVERS_SYS: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> core_rst); // R3

  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && gap_q < GAP_MAX) |-> core_rst); // R3

  AST_CORE_DROP: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && gap_q == GAP_MAX) |-> !core_rst); // R3

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (bus_sel && !bus_wr && bus_addr[3:2] != 2'b00) |-> (bus_rdata == '0)); // R5

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rdata[DATA_W-1:10] == '0) && !bus_rdata[5]); // R5
endmodule

bind rst_cause_ctrl rstc_chk #(.CORE_DLY(CORE_DLY), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .cfg_loaded   (cfg_loaded),
  .clk_stable   (clk_stable),
  .sw_req       (sw_req),
  .cfg_mismatch (cfg_mismatch),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .sys_rst      (sys_rst),
  .core_rst     (core_rst)
);

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb;
  localparam int PU   = 40;
  localparam int CDLY = 8;

  logic        clk = 1'b0;
  logic        por_n, regulator_en, cfg_loaded, clk_stable;
  logic        bor_req, pin_req, wdt_req, sw_req, cfg_mismatch;
  logic        in_sleep, in_idle, bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sys_rst, core_rst, wake_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 0;

  always #5 clk = ~clk;

  rst_cause_ctrl #(.PU_CYCLES(PU), .CORE_DLY(CDLY)) u_dut (
    .clk(clk), .por_n(por_n), .regulator_en(regulator_en),
    .cfg_loaded(cfg_loaded), .clk_stable(clk_stable),
    .bor_req(bor_req), .pin_req(pin_req), .wdt_req(wdt_req),
    .sw_req(sw_req), .cfg_mismatch(cfg_mismatch),
    .in_sleep(in_sleep), .in_idle(in_idle),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst(sys_rst), .core_rst(core_rst), .wake_evt(wake_evt)
  );

  // behavioural reference model
  int          m_rel, m_st, m_pu, m_core;
  logic [1:0]  qb, qp, qw;
  logic [9:0]  m_flags;
  logic        m_wake;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_rel = 0; m_st = 0; m_pu = 0; m_core = 0;
      qb = 0; qp = 0; qw = 0; m_flags = 10'h003; m_wake = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      logic sb, sp, sw, lp, wr, anyr;
      logic [9:0] f, wm;
      sb = qb[1]; sp = qp[1]; sw = qw[1];
      qb = {qb[0], bor_req}; qp = {qp[0], pin_req}; qw = {qw[0], wdt_req};
      lp = in_sleep | in_idle;
      wr = sw & !lp;
      m_wake = sw & lp;
      anyr = sb | sp | wr | sw_req | cfg_mismatch;
      f = m_flags;
      wm = bus_wdata[9:0] & 10'h3DF;
      if (bus_sel && bus_wr) begin
        case (bus_addr[3:2])
          2'd0: f = wm;
          2'd1: f = f & ~wm;
          2'd2: f = f | wm;
          default: f = f ^ wm;
        endcase
      end
      if (sb) f = (f & 10'h101) | 10'h002;
      else begin
        if (sp) f = f | 10'h080;
        if (sp && in_sleep) f = f | 10'h008;
        if (sp && in_idle) f = f | 10'h004;
        if (sw_req) f = f | 10'h040;
        if (wr) f = f | 10'h010;
        if (cfg_mismatch) f = f | 10'h200;
      end
      m_flags = f;
      if (m_st != 2) m_core = 0; else if (m_core < CDLY) m_core++;
      if (anyr) m_st = 1;
      else if (m_st == 0) begin
        if (regulator_en || m_pu == PU - 1) m_st = 1;
        else m_pu++;
      end else if (m_st == 1 && cfg_loaded && clk_stable) m_st = 2;
    end
  end

  always @(negedge clk) begin
    #2;
    if (!fin) begin
      n_chk += 3;
      if (sys_rst !== (m_st != 2)) begin
        n_bad++; $display("FAIL R1 sys_rst act=%0b exp=%0b t=%0t", sys_rst, (m_st != 2), $time);
      end
      if (core_rst !== (m_st != 2 || m_core != CDLY)) begin
        n_bad++; $display("FAIL R3 core_rst act=%0b exp=%0b t=%0t", core_rst, (m_st != 2 || m_core != CDLY), $time);
      end
      if (wake_evt !== m_wake) begin
        n_bad++; $display("FAIL R9 wake_evt act=%0b exp=%0b t=%0t", wake_evt, m_wake, $time);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wait_run();
    int k = 0;
    while ((sys_rst || core_rst) && k < 400) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic fire(input int src, output int lat);
    @(negedge clk);
    case (src)
      0: bor_req = 1;
      1: pin_req = 1;
      2: wdt_req = 1;
      3: sw_req = 1;
      default: cfg_mismatch = 1;
    endcase
    lat = 0;
    do begin @(negedge clk); lat++; end while (!sys_rst && lat < 20);
    bor_req = 0; pin_req = 0; wdt_req = 0; sw_req = 0; cfg_mismatch = 0;
    wait_run();
  endtask

  task automatic power_cycle(input logic reg_on, output int high_cnt);
    @(negedge clk);
    por_n = 0; regulator_en = reg_on;
    repeat (3) @(negedge clk);
    check("R6 sys_rst held in power-on", {31'd0, sys_rst}, 32'd1);
    check("R6 core_rst held in power-on", {31'd0, core_rst}, 32'd1);
    por_n = 1;
    high_cnt = 0;
    forever begin
      @(negedge clk);
      if (!sys_rst || high_cnt > 500) break;
      high_cnt++;
    end
  endtask

  initial begin
    logic [31:0] rd;
    int n, lat;
    por_n = 0; regulator_en = 0; cfg_loaded = 1; clk_stable = 1;
    bor_req = 0; pin_req = 0; wdt_req = 0; sw_req = 0; cfg_mismatch = 0;
    in_sleep = 0; in_idle = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;

    // R4 regulator off: 2 release + PU wait cycles high
    power_cycle(1'b0, n);
    check("R4 sys_rst cycles, regulator off", n, PU + 2);
    n = 0;
    while (core_rst && n < 50) begin n++; @(negedge clk); end
    check("R3 core_rst tail cycles", n, CDLY);
    bus_read(4'h0, rd);
    check("R6 flags after power-on", rd, 32'h003);

    // R4 regulator on: power-up wait bypassed
    power_cycle(1'b1, n);
    check("R4 sys_rst cycles, regulator on", n, 3);
    wait_run();
    bus_read(4'h0, rd);
    check("R6 flags after second power-on", rd, 32'h003);

    bus_write(4'h4, 32'h3FF);
    bus_read(4'h0, rd);
    check("R10 clear alias empties flags", rd, 32'h000);

    // R1 / R8 individual causes
    fire(1, lat);
    check("R1 pin latency", lat, 3);
    bus_read(4'h0, rd);
    check("R8 pin flag only", rd, 32'h080);
    fire(3, lat);
    check("R1 software latency", lat, 1);
    bus_read(4'h0, rd);
    check("R8 software flag added", rd, 32'h0C0);
    fire(4, lat);
    check("R1 mismatch latency", lat, 1);
    bus_read(4'h0, rd);
    check("R8 mismatch flag added", rd, 32'h2C0);
    fire(2, lat);
    check("R1 watchdog latency", lat, 3);
    bus_read(4'h0, rd);
    check("R8 watchdog flag added", rd, 32'h2D0);
    in_sleep = 1;
    fire(1, lat);
    in_sleep = 0;
    bus_read(4'h0, rd);
    check("R8 pin during sleep sets sleep flag", rd, 32'h2D8);
    in_idle = 1;
    fire(1, lat);
    in_idle = 0;
    // watchdog in idle does not reach here; idle flag set by pin reset
    bus_read(4'h0, rd);
    check("R8 pin during idle sets idle flag", rd, 32'h2DC);

    // R7 brown-out
    bus_write(4'h8, 32'h101);
    bus_read(4'h0, rd);
    check("R10 set alias", rd, 32'h3DD);
    fire(0, lat);
    check("R1 brown-out latency", lat, 3);
    bus_read(4'h0, rd);
    check("R7 brown-out keeps power-on and standby", rd, 32'h103);

    // R2 release waits for readiness
    cfg_loaded = 0;
    @(negedge clk); sw_req = 1;
    @(negedge clk); sw_req = 0;
    repeat (20) @(negedge clk);
    check("R2 held while config not loaded", {31'd0, sys_rst}, 32'd1);
    cfg_loaded = 1; clk_stable = 0;
    repeat (10) @(negedge clk);
    check("R2 held while clock unstable", {31'd0, sys_rst}, 32'd1);
    clk_stable = 1;
    @(negedge clk);
    check("R2 release one edge after ready", {31'd0, sys_rst}, 32'd0);
    wait_run();

    // R9 watchdog wake in idle
    in_idle = 1;
    @(negedge clk); wdt_req = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check("R9 no reset on low-power watchdog", {31'd0, sys_rst}, 32'd0);
      if (i == 3) check("R9 wake after three edges", {31'd0, wake_evt}, 32'd1);
    end
    wdt_req = 0;
    repeat (4) @(negedge clk);
    check("R9 wake drops", {31'd0, wake_evt}, 32'd0);
    in_idle = 0;
    bus_read(4'h0, rd);
    check("R9 flags unchanged by wake", rd, 32'h143);

    // R10 / R5 / R11 alias writes and reads
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, rd);
    check("R10 direct write masks unimplemented", rd, 32'h3DF);
    bus_write(4'h4, 32'h0F0);
    bus_read(4'h0, rd);
    check("R10 clear alias", rd, 32'h30F);
    bus_write(4'h8, 32'h020);
    bus_read(4'h0, rd);
    check("R5 bit 5 stays zero", rd, 32'h30F);
    bus_write(4'hC, 32'h3FF);
    bus_read(4'h0, rd);
    check("R10 invert alias", rd, 32'h0D0);
    bus_read(4'h4, rd);
    check("R5 clear alias reads zero", rd, 32'h0);
    bus_read(4'h8, rd);
    check("R5 set alias reads zero", rd, 32'h0);
    bus_read(4'hC, rd);
    check("R5 invert alias reads zero", rd, 32'h0);
    check("R11 sys_rst unaffected by writes", {31'd0, sys_rst}, 32'd0);
    check("R11 core_rst unaffected by writes", {31'd0, core_rst}, 32'd0);

    // R12 same-edge hardware and bus update
    bus_write(4'h4, 32'h3FF);
    @(negedge clk);
    sw_req = 1; bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 32'h080;
    @(negedge clk);
    sw_req = 0; bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    wait_run();
    bus_read(4'h0, rd);
    check("R12 hardware flag over bus write", rd, 32'h0C0);

    repeat (3) @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired, run hung");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule